// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim and Complete

This block gathers a configurable number of external interrupt sources and steers them to a configurable number of hart contexts. A context stands for one privilege level of one hardware thread, and each context has its own interrupt output. The default build has 10 sources and 9 contexts. That matches one core with a single context plus four cores with two contexts each.

Software uses a word-addressed register port with separate read and write strobes. Through it, software sets a priority for each source, an enable mask for each context and a threshold for each context. It picks edge or level triggering per source, and for edge sources it picks whether edges that arrive during service are queued or dropped. A context services an interrupt in two steps. It first reads its claim register, which returns the winning source ID and takes that source into service. Once the handler is done, it writes that ID back to the same register to release the source.

Address map (8-bit word address): source s priority at `s` (1..NSRC); enable mask of context c at `0x20+c`; threshold of context c at `0x40+c`; claim/complete of context c at `0x60+c`; trigger-type mask at `0x80`; queue-policy mask at `0x81`; pending mask (read only) at `0x82`; in-service mask (read only) at `0x83`. In every mask, bit s stands for source s and bit 0 is unused.

Top module: `plic_core`

## Requirements
- R1: After reset all priorities, enables, thresholds, trigger types and policies read as 0, every irq_o bit is low, and a claim read returns 0.
- R2: The priority of source s is read and written at address s (low PW bits). A source whose priority is 0 never raises a line and is never returned by a claim.
- R3: A source can raise irq_o[c] or be claimed by context c only if bit s of that context's enable mask (address 0x20+c) is set. With nothing pending, every irq_o bit is low.
- R4: irq_o[c] is high exactly when the best eligible source for context c has a priority greater than or equal to that context's threshold (address 0x40+c).
- R5: A read of address 0x60+c returns the eligible source with the highest priority, picking the lowest ID on a tie, and returns 0 when no source is eligible. The value returned never exceeds NSRC.
- R6: A claim clears the source's pending bit and sets its in-service bit (mask at 0x83) in the same cycle. No context can claim that source again until it is completed. A source enters service only through a claim read.
- R7: Writing ID s to address 0x60+c completes source s. A write with an ID of 0, an ID above NSRC, or the ID of a source that is not in service leaves the in-service mask unchanged.
- R8: A level source (trigger bit 0 at 0x80) is pending while its input is high and it is not in service. After completion it is pending again only if its input is still high. A source is never pending and in service at once.
- R9: An edge source (trigger bit 1) becomes pending on a rising edge of its input and stays pending after the input falls.
- R10: Under the drop policy (bit 0 at 0x81), rising edges on an edge source while it is in service are discarded, so completion leaves it idle.
- R11: Under the queue policy (bit 1 at 0x81), each rising edge on an edge source while it is in service increments a 3-bit counter that saturates at 7. Each completion with a non-zero count re-pends the source and decrements the count, so 10 queued edges yield exactly 7 further claims.
- R12: Read data appears on rdata_o in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Source inputs, bit k is source k+1 |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 8 | Word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| irq_o | output | NCTX | One interrupt line per context |

## Verification
The arbiter is driven with a group of level sources that mixes tied priorities, a zero priority and enable masks that differ between contexts. The order of successive claims then separates the tie-break rule from the zero-priority exclusion, and shows that a source held by one context is locked out for the others. A single source is swept against several thresholds, including one equal to its priority, to pin down where the comparison boundary lies. Pulsed edge sources are fed edges while in service, once under the drop policy and once under the queue policy. Ten edges under the queue policy tell a saturating 3-bit counter apart from an unlimited count and from a single sticky flag.

// File: rtl/plic_core.sv
module plic_core #(
  parameter int NSRC = 10,
  parameter int NCTX = 9,
  parameter int PW   = 3,
  parameter int CW   = 3,
  parameter int DW   = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [7:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [NCTX-1:0] irq_o
);
  localparam int IW = $clog2(NSRC + 1);

  logic [2:0] rgn;
  logic [4:0] idx;
  logic ctx_ok, rd_claim, wr_claim;
  logic [NSRC:1] src, pend, insvc, trig, queue, claim_v, comp_v;
  logic [PW-1:0] prio [1:NSRC];
  logic [NSRC:1] en [NCTX];
  logic [PW-1:0] thr [NCTX];
  logic [IW-1:0] best_id [NCTX];
  logic [PW-1:0] best_p [NCTX];
  logic [IW-1:0] claim_id;
  logic [DW-1:0] rd_val;

  assign rgn      = addr_i[7:5];
  assign idx      = addr_i[4:0];
  assign src      = src_i;
  assign ctx_ok   = int'(idx) < NCTX;
  assign rd_claim = rd_i && rgn == 3'd3 && ctx_ok;
  assign wr_claim = wr_i && rgn == 3'd3 && ctx_ok;

  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      best_id[c] = '0;
      best_p[c]  = '0;
      for (int s = 1; s <= NSRC; s++)
        if (pend[s] && en[c][s] && prio[s] > best_p[c]) begin
          best_p[c]  = prio[s];
          best_id[c] = IW'(s);
        end
    end
  end

  always_comb begin
    claim_id = '0;
    for (int c = 0; c < NCTX; c++)
      if (int'(idx) == c) claim_id = best_id[c];
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    assign irq_o[c] = (best_id[c] != '0) && (best_p[c] >= thr[c]);
  end

  for (genvar s = 1; s <= NSRC; s++) begin : g_src
    logic p_q, v_q, s_q, edge_s, inc;
    logic [CW-1:0] cnt_q, cnt_nx;

    assign claim_v[s] = rd_claim && claim_id == IW'(s);
    assign comp_v[s]  = wr_claim && wdata_i == DW'(s) && v_q;
    assign pend[s]    = p_q;
    assign insvc[s]   = v_q;
    assign edge_s     = src[s] & ~s_q;
    assign inc        = trig[s] && queue[s] && edge_s && (v_q || claim_v[s]) && cnt_q != '1;
    assign cnt_nx     = cnt_q + CW'(inc);

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        p_q <= 1'b0; v_q <= 1'b0; s_q <= 1'b0; cnt_q <= '0;
      end else begin
        s_q <= src[s];
        if (claim_v[s]) begin
          v_q <= 1'b1; p_q <= 1'b0; cnt_q <= cnt_nx;
        end else if (comp_v[s]) begin
          v_q <= 1'b0;
          if (!trig[s]) begin
            p_q <= src[s]; cnt_q <= '0;
          end else if (cnt_nx != '0) begin
            p_q <= 1'b1; cnt_q <= cnt_nx - 1'b1;
          end
        end else if (v_q) cnt_q <= cnt_nx;
        else if (!trig[s]) p_q <= src[s];
        else if (edge_s) p_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      trig <= '0; queue <= '0;
      for (int s = 1; s <= NSRC; s++) prio[s] <= '0;
      for (int c = 0; c < NCTX; c++) begin en[c] <= '0; thr[c] <= '0; end
    end else if (wr_i) begin
      case (rgn)
        3'd0: for (int s = 1; s <= NSRC; s++) if (int'(idx) == s) prio[s] <= wdata_i[PW-1:0];
        3'd1: for (int c = 0; c < NCTX; c++) if (int'(idx) == c) en[c] <= wdata_i[NSRC:1];
        3'd2: for (int c = 0; c < NCTX; c++) if (int'(idx) == c) thr[c] <= wdata_i[PW-1:0];
        3'd4: begin
          if (idx == 5'd0) trig  <= wdata_i[NSRC:1];
          if (idx == 5'd1) queue <= wdata_i[NSRC:1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    case (rgn)
      3'd0: for (int s = 1; s <= NSRC; s++) if (int'(idx) == s) rd_val = DW'(prio[s]);
      3'd1: for (int c = 0; c < NCTX; c++) if (int'(idx) == c) rd_val = DW'({en[c], 1'b0});
      3'd2: for (int c = 0; c < NCTX; c++) if (int'(idx) == c) rd_val = DW'(thr[c]);
      3'd3: rd_val = DW'(claim_id);
      3'd4: case (idx)
        5'd0: rd_val = DW'({trig, 1'b0});
        5'd1: rd_val = DW'({queue, 1'b0});
        5'd2: rd_val = DW'({pend, 1'b0});
        5'd3: rd_val = DW'({insvc, 1'b0});
        default: ;
      endcase
      default: ;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end
endmodule

// File: rtl/plic_core_chk.sv
module plic_core_chk #(
  parameter int NSRC = 10,
  parameter int NCTX = 9,
  parameter int DW   = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rd_i,
  input logic            rd_claim,
  input logic            wr_claim,
  input logic [NSRC:1]   pend,
  input logic [NSRC:1]   insvc,
  input logic [NSRC:1]   comp_v,
  input logic [NCTX-1:0] irq_o,
  input logic [DW-1:0]   rdata_o
);
  assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend & insvc) == '0);

  assert_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend == '0 |-> irq_o == '0);

  assert_enter_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insvc & ~$past(insvc)) != '0 |-> $past(rd_claim));

  assert_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_claim |=> rdata_o <= DW'(NSRC));

  assert_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_claim && !rd_i && comp_v == '0) |=> $stable(insvc));
endmodule

bind plic_core plic_core_chk #(.NSRC(NSRC), .NCTX(NCTX), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .rd_claim(rd_claim),
  .wr_claim(wr_claim), .pend(pend), .insvc(insvc), .comp_v(comp_v),
  .irq_o(irq_o), .rdata_o(rdata_o)
);

// File: tb/test_plic_core.sv
module test_plic_core;
  logic        clk = 0, rst_n = 0, rd = 0, wr = 0;
  logic [9:0]  src = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [8:0]  irq;
  int total = 0, fails = 0;
  int v;

  always #4 clk = ~clk;

  plic_core i_plic_core (.clk_i(clk), .rst_ni(rst_n), .src_i(src), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk); wr = 1; addr = 8'(a); wdata = 32'(d);
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input int a, output int d);
    @(negedge clk); rd = 1; addr = 8'(a);
    @(negedge clk); rd = 0; d = int'(rdata);
  endtask

  task automatic pulse(input int bitn);
    @(negedge clk); src[bitn] = 1'b1;
    @(negedge clk); src[bitn] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq", int'(irq), 0);
    rd_reg(1, v);   chk("R1 prio", v, 0);
    rd_reg(8'h20, v); chk("R1 enable", v, 0);
    rd_reg(8'h80, v); chk("R1 trig", v, 0);
    rd_reg(8'h60, v); chk("R1 claim", v, 0);
    chk("R12 hold", int'(rdata), 0);
  endtask

  task automatic t_arb;
    wr_reg(1, 2); wr_reg(2, 5); wr_reg(3, 5); wr_reg(4, 0);
    wr_reg(8'h20, 32'h1E); wr_reg(8'h21, 32'h02);
    rd_reg(2, v); chk("R2 readback", v, 5);
    @(negedge clk); src[3:0] = 4'hF; @(negedge clk);
    chk("R3 ctx0", int'(irq[0]), 1);
    chk("R3 ctx1", int'(irq[1]), 1);
    chk("R3 ctx2 disabled", int'(irq[2]), 0);
    rd_reg(8'h60, v); chk("R5 tie lowest", v, 2);
    rd_reg(8'h61, v); chk("R3 ctx1 claim", v, 1);
    rd_reg(8'h60, v); chk("R5 next", v, 3);
    rd_reg(8'h60, v); chk("R2 zero prio", v, 0);
    chk("R2 no line", int'(irq[0]), 0);
    rd_reg(8'h61, v); chk("R6 locked", v, 0);
    rd_reg(8'h83, v); chk("R6 insvc", v, 14);
    wr_reg(8'h60, 0); wr_reg(8'h60, 11); wr_reg(8'h60, 4);
    rd_reg(8'h83, v); chk("R7 ignored", v, 14);
    @(negedge clk); src[3:0] = 4'h0; @(negedge clk);
    wr_reg(8'h60, 2); wr_reg(8'h61, 1); wr_reg(8'h60, 3);
    rd_reg(8'h83, v); chk("R7 released", v, 0);
    rd_reg(8'h82, v); chk("R8 low idle", v, 0);
  endtask

  task automatic t_level;
    wr_reg(6, 3); wr_reg(8'h22, 32'h40);
    @(negedge clk); src[5] = 1'b1; @(negedge clk);
    rd_reg(8'h62, v); chk("R8 claim", v, 6);
    rd_reg(8'h82, v); chk("R8 not pending in service", v, 0);
    wr_reg(8'h62, 6);
    chk("R8 repend high", int'(irq[2]), 1);
    rd_reg(8'h62, v); chk("R8 reclaim", v, 6);
    @(negedge clk); src[5] = 1'b0;
    wr_reg(8'h62, 6);
    chk("R8 no repend low", int'(irq[2]), 0);
    rd_reg(8'h62, v); chk("R8 claim none", v, 0);
  endtask

  task automatic t_thr;
    wr_reg(7, 4); wr_reg(8'h23, 32'h80); wr_reg(8'h43, 5);
    @(negedge clk); src[6] = 1'b1; @(negedge clk);
    chk("R4 below", int'(irq[3]), 0);
    wr_reg(8'h43, 4);
    chk("R4 equal", int'(irq[3]), 1);
    wr_reg(8'h43, 7);
    chk("R4 far below", int'(irq[3]), 0);
    @(negedge clk); src[6] = 1'b0; @(negedge clk);
  endtask

  task automatic t_edge_drop;
    wr_reg(8'h80, 32'h100); wr_reg(8, 2); wr_reg(8'h24, 32'h100);
    pulse(7);
    chk("R9 latched", int'(irq[4]), 1);
    rd_reg(8'h64, v); chk("R9 claim", v, 8);
    pulse(7); pulse(7);
    wr_reg(8'h64, 8);
    chk("R10 dropped", int'(irq[4]), 0);
    rd_reg(8'h64, v); chk("R10 claim none", v, 0);
  endtask

  task automatic t_edge_queue;
    wr_reg(8'h80, 32'h300); wr_reg(8'h81, 32'h200);
    wr_reg(9, 1); wr_reg(8'h25, 32'h200);
    pulse(8);
    rd_reg(8'h65, v); chk("R11 first claim", v, 9);
    for (int k = 0; k < 10; k++) pulse(8);
    rd_reg(8'h82, v); chk("R11 not pending in service", v & 32'h200, 0);
    for (int k = 0; k < 7; k++) begin
      wr_reg(8'h65, 9);
      chk("R11 repend", int'(irq[5]), 1);
      rd_reg(8'h65, v); chk("R11 queued claim", v, 9);
    end
    wr_reg(8'h65, 9);
    chk("R11 saturated", int'(irq[5]), 0);
    rd_reg(8'h65, v); chk("R11 exhausted", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_arb();
    t_level();
    t_thr();
    t_edge_drop();
    t_edge_queue();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule